// File: doc/BRIEF.md
# Raster Timing Engine with Programmable Fetch Trigger

This block generates the raster timing for a video-mode display link. Two cascaded counters walk each frame through the visible pixels, the front porch, the sync pulse and the back porch, first along a line and then along the frame. From their positions the block drives horizontal sync, vertical sync and a data-valid strobe. It also drives a one-cycle fetch trigger, which tells the upstream pixel pipeline to start reading the next frame early, while the raster is still in the vertical front porch. Each sync output has its own polarity bit. A serial-panel mode forces both syncs active-high. While data is valid, the pixel output passes the incoming pixel. When upstream data underflows, it shows a fill colour instead. Outside the visible area the output is zero, which is the border colour.

Software writes the timing fields while the engine is stopped. The engine copies them into its own holding registers on the cycle it starts. The fetch position is an absolute count. A pixel counter is loaded with 1 at the first pixel of the first vsync line and advances every cycle after that. The trigger fires when this counter equals the programmed value. Software normally sets that value to the first pixel of a line in the front porch. The block also reports a frame count in a second form. This form already counts the frame whose fetch has begun, so software sees the upcoming frame as soon as its fetch starts. Clearing the enable takes effect only at a frame edge, so a frame is never cut off partway through.

The controller has three states. ST_IDLE is stopped. ST_RUN is running with the enable held. ST_DRAIN is running with the enable cleared, waiting for the frame edge. The transitions are: ST_IDLE to ST_RUN when enable is high (the start edge, which clears the counters and latches the settings); ST_RUN to ST_DRAIN when enable is low; ST_DRAIN back to ST_RUN when enable returns high (the stop is cancelled and the counters are kept); and ST_DRAIN to ST_IDLE at the last pixel before the vsync line begins.

Top module: `video_timing_gen`

## Requirements
- R1: After reset the engine is stopped. `running`, `de`, `fetch_start`, `hsync`, `vsync`, `frame_cnt` and `pix_out` are all 0.
- R2: If `enable` is high at a clock edge while the engine is stopped, `running` is 1 from the next cycle. In that first cycle the raster is at line 0, pixel 0 (`line_cnt` = 0, `frame_cnt` = 0), and all configuration inputs are captured at that edge.
- R3: Each line lasts active+front+sync+back cycles. Pixel positions 0..active-1 are visible, the front porch follows, and the horizontal sync is asserted for exactly `cfg_h_sync` cycles starting at position active+front. The back porch comes last.
- R4: Lines follow the same order down the frame. Vertical sync is asserted for whole lines, from line v_active+v_front for exactly `cfg_v_sync` lines.
- R5: `de` is high only when both the pixel position and the line are in their visible ranges. While `de` is high, `pix_out` equals `pix_in`, or `cfg_fill` when `pix_underflow` is 1. Otherwise `pix_out` is 0.
- R6: Each sync output is the active level XOR its polarity bit (1 = active-low). When `cfg_dsi` is 1, both polarity bits are treated as 0. While stopped, each sync sits at its inactive level.
- R7: With `cfg_fetch_en` = 1, `fetch_start` is high for exactly the one cycle in which the pixel counter equals `cfg_fetch_pos`. The counter is 1 at the first pixel of each vsync line and advances by one per cycle. The trigger never fires before the first vsync line of a run, and never fires with `cfg_fetch_en` = 0.
- R8: `line_cnt` gives the current line, 0-based, with line 0 being the first visible line. `frame_cnt` increases by one on the first cycle of every vsync line.
- R9: `frame_cnt_rpt` equals `frame_cnt` + 1 from the cycle after a fetch trigger until `frame_cnt` next increases. At all other times it equals `frame_cnt`.
- R10: After `enable` is cleared, the engine runs on unchanged, including during a vsync it is already in. It stops after the last pixel before the next vsync line, with no further vsync pulse. If `enable` returns high before that point, the run continues with no restart.
- R11: Changes on the configuration inputs while the engine is running have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one pixel per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Start request; clearing it requests a stop at the frame edge |
| cfg_h_active | input | HW | Visible pixels per line |
| cfg_h_front | input | HW | Horizontal front porch length |
| cfg_h_sync | input | HW | Horizontal sync width |
| cfg_h_back | input | HW | Horizontal back porch length |
| cfg_v_active | input | VW | Visible lines per frame |
| cfg_v_front | input | VW | Vertical front porch lines |
| cfg_v_sync | input | VW | Vertical sync lines |
| cfg_v_back | input | VW | Vertical back porch lines |
| cfg_hs_low | input | 1 | Horizontal sync active-low when 1 |
| cfg_vs_low | input | 1 | Vertical sync active-low when 1 |
| cfg_dsi | input | 1 | Serial-panel mode; forces active-high syncs |
| cfg_fetch_en | input | 1 | Enables the fetch trigger |
| cfg_fetch_pos | input | PW | Pixel-counter value at which the trigger fires |
| cfg_fill | input | CW | Colour shown on underflow |
| pix_in | input | CW | Upstream pixel |
| pix_underflow | input | 1 | Upstream has no valid pixel |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data valid |
| fetch_start | output | 1 | One-cycle fetch trigger |
| pix_out | output | CW | Output pixel |
| line_cnt | output | VW+2 | Current line |
| frame_cnt | output | FW | Frames counted at vsync starts |
| frame_cnt_rpt | output | FW | Frame count including a fetch already started |
| running | output | 1 | Engine active (ST_RUN or ST_DRAIN) |

## Verification
A stray pixel or line counter shows up at once. `de` and the sync edges move away from their positions inside the same line, and `line_cnt` drifts within one line time. The pixel counter for the fetch trigger is a separate register, so an error there appears only once per frame. It shows as a trigger in the wrong cycle, or as `frame_cnt_rpt` stepping ahead too early or too late. Comparing every output on every cycle against a position-based model catches these within one frame. A controller stuck in the wrong state shows as `running` staying high past the pre-vsync edge, or dropping when no stop was asked for.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } vtg_state_t;

endpackage

// File: rtl/vtg_axis_cnt.sv
// One raster axis: counts 0..last, wrapping, and flags a compare match.
module vtg_axis_cnt #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] last,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt,
    output logic         match
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= (cnt == last) ? '0 : cnt + 1'b1;
        end
    end

    assign match = (cnt == cmp);

endmodule

// File: rtl/vtg_region.sv
// Decodes the position on one axis into visible and sync regions.
module vtg_region #(
    parameter int W  = 14,
    parameter int LW = 12
) (
    input  logic [W-1:0]  cnt,
    input  logic [LW-1:0] act_len,
    input  logic [LW-1:0] fp_len,
    input  logic [LW-1:0] sync_len,
    output logic          in_act,
    output logic          in_sync
);

    logic [W-1:0] sync_beg;
    logic [W-1:0] sync_end;

    always_comb begin
        sync_beg = W'(act_len) + W'(fp_len);
        sync_end = sync_beg + W'(sync_len);
        in_act   = (cnt < W'(act_len));
        in_sync  = (cnt >= sync_beg) && (cnt < sync_end);
    end

endmodule

// File: rtl/vtg_ctrl.sv
// Run/stop controller: a cleared enable is honoured only at the frame edge.
module vtg_ctrl
    import vtg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       at_edge,
    output logic       start,
    output logic       keep,
    output logic       running,
    output vtg_state_t state
);

    vtg_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (enable) state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (!enable) state_nx = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (enable)       state_nx = ST_RUN;
                else if (at_edge) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        start   = (state == ST_IDLE) && (state_nx == ST_RUN);
        running = (state != ST_IDLE);
        keep    = (state_nx != ST_IDLE);
    end

endmodule

// File: rtl/vtg_fetch_track.sv
// Absolute pixel counter from vsync start, fetch trigger and frame counts.
module vtg_fetch_track #(
    parameter int PW = 24,
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic          vs_hit,
    input  logic          running,
    input  logic          fetch_en,
    input  logic [PW-1:0] fetch_pos,
    output logic          fetch_start,
    output logic [FW-1:0] frame_cnt,
    output logic [FW-1:0] frame_rpt
);

    logic [PW-1:0] pcnt;
    logic          pvalid;
    logic          fetched;

    always_comb begin
        fetch_start = running && pvalid && fetch_en && (pcnt == fetch_pos);
        frame_rpt   = frame_cnt + FW'(fetched && fetch_en && running);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt      <= '0;
            pvalid    <= 1'b0;
            fetched   <= 1'b0;
            frame_cnt <= '0;
        end else if (clear) begin
            pcnt      <= '0;
            pvalid    <= 1'b0;
            fetched   <= 1'b0;
            frame_cnt <= '0;
        end else if (vs_hit) begin
            pcnt      <= PW'(1);
            pvalid    <= 1'b1;
            fetched   <= 1'b0;
            frame_cnt <= frame_cnt + 1'b1;
        end else begin
            if (step && pvalid) pcnt <= pcnt + 1'b1;
            if (fetch_start)    fetched <= 1'b1;
        end
    end

endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
    import vtg_pkg::*;
#(
    parameter int HW       = 12,
    parameter int VW       = 12,
    parameter int PW       = 24,
    parameter int FW       = 16,
    parameter int CW       = 8,
    parameter int FILL_RST = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [HW-1:0] cfg_h_active,
    input  logic [HW-1:0] cfg_h_front,
    input  logic [HW-1:0] cfg_h_sync,
    input  logic [HW-1:0] cfg_h_back,
    input  logic [VW-1:0] cfg_v_active,
    input  logic [VW-1:0] cfg_v_front,
    input  logic [VW-1:0] cfg_v_sync,
    input  logic [VW-1:0] cfg_v_back,
    input  logic          cfg_hs_low,
    input  logic          cfg_vs_low,
    input  logic          cfg_dsi,
    input  logic          cfg_fetch_en,
    input  logic [PW-1:0] cfg_fetch_pos,
    input  logic [CW-1:0] cfg_fill,
    input  logic [CW-1:0] pix_in,
    input  logic          pix_underflow,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          fetch_start,
    output logic [CW-1:0] pix_out,
    output logic [VW+1:0] line_cnt,
    output logic [FW-1:0] frame_cnt,
    output logic [FW-1:0] frame_cnt_rpt,
    output logic          running
);

    localparam int HTW = HW + 2;
    localparam int VTW = VW + 2;

    // settings captured at the start edge
    logic [HW-1:0] ha_q, hfp_q, hs_q, hbp_q;
    logic [VW-1:0] va_q, vfp_q, vs_q, vbp_q;
    logic          hs_low_q, vs_low_q, dsi_q, fe_q;
    logic [PW-1:0] fpos_q;
    logic [CW-1:0] fill_q;

    logic          start, keep;
    vtg_state_t    state;

    logic [HTW-1:0] h_last, hcnt;
    logic [VTW-1:0] v_last, v_pre_sync, vcnt;
    logic           h_end, v_at_pre;
    logic           h_in_act, h_in_sync, v_in_act, v_in_sync;
    logic           at_edge, vs_hit;
    logic           hs_pol, vs_pol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ha_q     <= '0;
            hfp_q    <= '0;
            hs_q     <= '0;
            hbp_q    <= '0;
            va_q     <= '0;
            vfp_q    <= '0;
            vs_q     <= '0;
            vbp_q    <= '0;
            hs_low_q <= 1'b0;
            vs_low_q <= 1'b0;
            dsi_q    <= 1'b0;
            fe_q     <= 1'b0;
            fpos_q   <= '0;
            fill_q   <= CW'(FILL_RST);
        end else if (start) begin
            ha_q     <= cfg_h_active;
            hfp_q    <= cfg_h_front;
            hs_q     <= cfg_h_sync;
            hbp_q    <= cfg_h_back;
            va_q     <= cfg_v_active;
            vfp_q    <= cfg_v_front;
            vs_q     <= cfg_v_sync;
            vbp_q    <= cfg_v_back;
            hs_low_q <= cfg_hs_low;
            vs_low_q <= cfg_vs_low;
            dsi_q    <= cfg_dsi;
            fe_q     <= cfg_fetch_en;
            fpos_q   <= cfg_fetch_pos;
            fill_q   <= cfg_fill;
        end
    end

    always_comb begin
        h_last     = HTW'(ha_q) + HTW'(hfp_q) + HTW'(hs_q) + HTW'(hbp_q) - HTW'(1);
        v_last     = VTW'(va_q) + VTW'(vfp_q) + VTW'(vs_q) + VTW'(vbp_q) - VTW'(1);
        v_pre_sync = VTW'(va_q) + VTW'(vfp_q) - VTW'(1);
        hs_pol     = hs_low_q & ~dsi_q;
        vs_pol     = vs_low_q & ~dsi_q;
    end

    vtg_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .at_edge (at_edge),
        .start   (start),
        .keep    (keep),
        .running (running),
        .state   (state)
    );

    vtg_axis_cnt #(.W(HTW)) u_hcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .step  (running),
        .last  (h_last),
        .cmp   (h_last),
        .cnt   (hcnt),
        .match (h_end)
    );

    vtg_axis_cnt #(.W(VTW)) u_vcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .step  (running && h_end),
        .last  (v_last),
        .cmp   (v_pre_sync),
        .cnt   (vcnt),
        .match (v_at_pre)
    );

    vtg_region #(.W(HTW), .LW(HW)) u_hreg (
        .cnt      (hcnt),
        .act_len  (ha_q),
        .fp_len   (hfp_q),
        .sync_len (hs_q),
        .in_act   (h_in_act),
        .in_sync  (h_in_sync)
    );

    vtg_region #(.W(VTW), .LW(VW)) u_vreg (
        .cnt      (vcnt),
        .act_len  (va_q),
        .fp_len   (vfp_q),
        .sync_len (vs_q),
        .in_act   (v_in_act),
        .in_sync  (v_in_sync)
    );

    // last pixel before the first vsync line: the frame edge
    always_comb begin
        at_edge = h_end && v_at_pre;
        vs_hit  = running && at_edge && keep;
    end

    vtg_fetch_track #(.PW(PW), .FW(FW)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (start),
        .step        (running),
        .vs_hit      (vs_hit),
        .running     (running),
        .fetch_en    (fe_q),
        .fetch_pos   (fpos_q),
        .fetch_start (fetch_start),
        .frame_cnt   (frame_cnt),
        .frame_rpt   (frame_cnt_rpt)
    );

    // output process
    always_comb begin
        de       = running && h_in_act && v_in_act;
        hsync    = (running && h_in_sync) ^ hs_pol;
        vsync    = (running && v_in_sync) ^ vs_pol;
        pix_out  = de ? (pix_underflow ? fill_q : pix_in) : '0;
        line_cnt = vcnt;
    end

endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
    parameter int FW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          running,
    input logic          de,
    input logic          fetch_start,
    input logic          hsync,
    input logic          vsync,
    input logic          hs_pol,
    input logic          vs_pol,
    input logic [FW-1:0] frame_cnt,
    input logic [FW-1:0] frame_cnt_rpt
);

    // R5
    de_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> running);

    // R7
    fetch_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_start |-> running);

    // R7
    fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_start |=> !fetch_start);

    // R6
    idle_sync_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (hsync == hs_pol && vsync == vs_pol));

    // R10
    stop_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> !$past(enable));

    // R8
    frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |->
            (frame_cnt == $past(frame_cnt) || frame_cnt == $past(frame_cnt) + 1'b1));

    // R9
    rpt_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (frame_cnt_rpt == frame_cnt || frame_cnt_rpt == frame_cnt + 1'b1));

endmodule

bind video_timing_gen vtg_checker #(.FW(FW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .running       (running),
    .de            (de),
    .fetch_start   (fetch_start),
    .hsync         (hsync),
    .vsync         (vsync),
    .hs_pol        (hs_pol),
    .vs_pol        (vs_pol),
    .frame_cnt     (frame_cnt),
    .frame_cnt_rpt (frame_cnt_rpt)
);

// File: tb/sim_video_timing_gen.sv
module sim_video_timing_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [11:0] cfg_h_active = '0, cfg_h_front = '0, cfg_h_sync = '0, cfg_h_back = '0;
    logic [11:0] cfg_v_active = '0, cfg_v_front = '0, cfg_v_sync = '0, cfg_v_back = '0;
    logic        cfg_hs_low = 1'b0, cfg_vs_low = 1'b0, cfg_dsi = 1'b0, cfg_fetch_en = 1'b0;
    logic [23:0] cfg_fetch_pos = '0;
    logic [7:0]  cfg_fill = '0;
    logic [7:0]  pix_in = '0;
    logic        pix_underflow = 1'b0;
    logic        hsync, vsync, de, fetch_start, running;
    logic [7:0]  pix_out;
    logic [13:0] line_cnt;
    logic [15:0] frame_cnt, frame_cnt_rpt;

    always #10 clk = ~clk;

    video_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_h_active(cfg_h_active), .cfg_h_front(cfg_h_front),
        .cfg_h_sync(cfg_h_sync), .cfg_h_back(cfg_h_back),
        .cfg_v_active(cfg_v_active), .cfg_v_front(cfg_v_front),
        .cfg_v_sync(cfg_v_sync), .cfg_v_back(cfg_v_back),
        .cfg_hs_low(cfg_hs_low), .cfg_vs_low(cfg_vs_low), .cfg_dsi(cfg_dsi),
        .cfg_fetch_en(cfg_fetch_en), .cfg_fetch_pos(cfg_fetch_pos),
        .cfg_fill(cfg_fill), .pix_in(pix_in), .pix_underflow(pix_underflow),
        .hsync(hsync), .vsync(vsync), .de(de), .fetch_start(fetch_start),
        .pix_out(pix_out), .line_cnt(line_cnt), .frame_cnt(frame_cnt),
        .frame_cnt_rpt(frame_cnt_rpt), .running(running)
    );

    int n_chk = 0;
    int n_fail = 0;

    // bench copy of the intended settings
    int ha, hfp, hs, hbp, va, vfp, vs, vbp, hlo, vlo, dsi, fe, fpos, fill;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    task automatic apply_cfg();
        cfg_h_active  = 12'(ha);  cfg_h_front = 12'(hfp); cfg_h_sync = 12'(hs); cfg_h_back = 12'(hbp);
        cfg_v_active  = 12'(va);  cfg_v_front = 12'(vfp); cfg_v_sync = 12'(vs); cfg_v_back = 12'(vbp);
        cfg_hs_low    = 1'(hlo);  cfg_vs_low  = 1'(vlo);  cfg_dsi    = 1'(dsi);
        cfg_fetch_en  = 1'(fe);   cfg_fetch_pos = 24'(fpos); cfg_fill = 8'(fill);
    endtask

    task automatic scramble_cfg();
        cfg_h_active  = 12'($urandom_range(1, 30));
        cfg_h_front   = 12'($urandom_range(1, 30));
        cfg_h_sync    = 12'($urandom_range(1, 30));
        cfg_h_back    = 12'($urandom_range(1, 30));
        cfg_v_active  = 12'($urandom_range(1, 30));
        cfg_v_front   = 12'($urandom_range(1, 30));
        cfg_v_sync    = 12'($urandom_range(1, 30));
        cfg_v_back    = 12'($urandom_range(1, 30));
        cfg_hs_low    = ~cfg_hs_low;
        cfg_vs_low    = ~cfg_vs_low;
        cfg_dsi       = ~cfg_dsi;
        cfg_fetch_en  = ~cfg_fetch_en;
        cfg_fetch_pos = 24'($urandom_range(1, 50));
        cfg_fill      = ~cfg_fill;
    endtask

    // c_drop/c_up: short cancelled stop request; drop_at: final stop request
    task automatic run_cfg(input int drop_at, input int c_drop, input int c_up);
        int htot = ha + hfp + hs + hbp;
        int vtot = va + vfp + vs + vbp;
        int frm  = htot * vtot;
        int vs0  = (va + vfp) * htot;
        int hp   = (dsi != 0) ? 0 : hlo;
        int vp   = (dsi != 0) ? 0 : vlo;
        int m    = drop_at + 1;
        while (((m + 1) % frm) != vs0) m++;

        @(negedge clk);
        apply_cfg();
        enable = 1'b1;
        for (int t = 0; t <= m + 3; t++) begin
            @(negedge clk);
            if (t <= m) begin
                int h = t % htot;
                int v = (t / htot) % vtot;
                int e_de = (h < ha && v < va) ? 1 : 0;
                int e_hs = ((h >= ha + hfp && h < ha + hfp + hs) ? 1 : 0) ^ hp;
                int e_vs = ((v >= va + vfp && v < va + vfp + vs) ? 1 : 0) ^ vp;
                int seen = (t >= vs0) ? 1 : 0;
                int e_fr = (seen != 0) ? ((t - vs0) / frm + 1) : 0;
                int pc   = (seen != 0) ? ((t - vs0) % frm + 1) : 0;
                int e_fs = (fe != 0 && seen != 0 && pc == fpos) ? 1 : 0;
                int e_rp = e_fr + ((fe != 0 && seen != 0 && pc > fpos) ? 1 : 0);
                int e_px = (e_de != 0) ? ((pix_underflow) ? fill : int'(pix_in)) : 0;
                string tg = (t > 1) ? "/R11" : "";
                chk((t == 0) ? "R2" : "R10", "running", running, 1);
                chk({"R5", tg}, "de", de, e_de);
                chk({"R3/R6", tg}, "hsync", hsync, e_hs);
                chk({"R4/R6", tg}, "vsync", vsync, e_vs);
                chk((t == 0) ? "R2" : "R8", "line_cnt", line_cnt, v);
                chk((t == 0) ? "R2" : "R8", "frame_cnt", frame_cnt, e_fr);
                chk({"R7", tg}, "fetch_start", fetch_start, e_fs);
                chk("R9", "frame_cnt_rpt", frame_cnt_rpt, e_rp);
                chk("R5", "pix_out", pix_out, e_px);
                if (t == htot) chk("R11", "line_cnt after settings changed", line_cnt, 1);
            end else begin
                chk("R10", "running after stop", running, 0);
                chk("R10", "de after stop", de, 0);
                chk("R6", "idle hsync level", hsync, hp);
                chk("R6", "idle vsync level", vsync, vp);
                chk("R10", "fetch after stop", fetch_start, 0);
            end
            if (t == 1) scramble_cfg();
            if (t == c_drop) enable = 1'b0;
            if (t == c_up) enable = 1'b1;
            if (t == drop_at) enable = 1'b0;
            pix_in = 8'($urandom_range(0, 255));
            pix_underflow = ($urandom_range(0, 3) == 0);
        end
    endtask

    function automatic int frame_len();
        return (ha + hfp + hs + hbp) * (va + vfp + vs + vbp);
    endfunction

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "running", running, 0);
        chk("R1", "de", de, 0);
        chk("R1", "fetch_start", fetch_start, 0);
        chk("R1", "hsync", hsync, 0);
        chk("R1", "vsync", vsync, 0);
        chk("R1", "frame_cnt", frame_cnt, 0);
        chk("R1", "pix_out", pix_out, 0);

        // minimal porches, trigger on first vsync pixel, active-low hsync
        ha = 4; hfp = 1; hs = 1; hbp = 1; va = 2; vfp = 1; vs = 1; vbp = 1;
        hlo = 1; vlo = 0; dsi = 0; fe = 1; fpos = 1; fill = 8'hA5;
        run_cfg(2 * frame_len() + 2, -1, -1);

        // trigger on the last pixel of the frame, serial-panel mode forces high
        hlo = 1; vlo = 1; dsi = 1; fpos = frame_len();
        run_cfg(2 * frame_len() + 5, -1, -1);

        // active-low both, trigger disabled
        dsi = 0; fe = 0; fpos = 3;
        run_cfg(frame_len() + 7, -1, -1);

        // cancelled stop, then trigger at two lines before the frame end
        ha = 6; hfp = 2; hs = 2; hbp = 3; va = 3; vfp = 3; vs = 2; vbp = 1;
        hlo = 0; vlo = 1; fe = 1;
        fpos = (va + vfp + vs + vbp - 2) * (ha + hfp + hs + hbp) + 1;
        run_cfg(2 * frame_len() + 1, 1, 4);

        // stop requested on the cycle before vsync: the run goes one more frame
        fpos = 5;
        run_cfg((va + vfp) * (ha + hfp + hs + hbp) - 1, -1, -1);

        for (int k = 0; k < 8; k++) begin
            ha = $urandom_range(2, 12); hfp = $urandom_range(1, 4);
            hs = $urandom_range(1, 4);  hbp = $urandom_range(1, 4);
            va = $urandom_range(2, 6);  vfp = $urandom_range(1, 4);
            vs = $urandom_range(1, 4);  vbp = $urandom_range(1, 4);
            hlo = $urandom_range(0, 1); vlo = $urandom_range(0, 1);
            dsi = ($urandom_range(0, 3) == 0) ? 1 : 0;
            fe = ($urandom_range(0, 4) != 0) ? 1 : 0;
            fpos = $urandom_range(1, frame_len());
            fill = $urandom_range(0, 255);
            run_cfg($urandom_range(frame_len(), 2 * frame_len()), -1, -1);
        end

        summary();
        $finish;
    end

endmodule